// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block takes a fast source clock and produces a slower clock from it at one of four ratios: 1, 2, 4 or 8. A 2-bit ratio code selects the ratio. The code is not monotonic: 11 selects pass-through, while 00, 01 and 10 select the even ratios. At every even ratio the divided clock is high for half of its period and low for the other half. At ratio 1 the output is the source clock itself.

An active-high enable gates the output. It is sampled in step with the divider, so the output never shows a pulse shorter than a normal half-period. A change of ratio code is held back until the current output period has ended, so no period is ever cut short. The block drives a true output and its complement, for a downstream differential or paired driver.

Top module: `clkdiv_top`

## Requirements
- R1: Ratio code 00 divides by 2, 01 divides by 4, 10 divides by 8, and 11 passes the source clock through (divide-by-1).
- R2: At ratios 2, 4 and 8 the output is high for exactly half of its period, measured in source cycles, and each period starts with its high half.
- R3: While the applied enable is low, clkOut is low and clkOutN is high.
- R4: The enable is sampled only on the source rising edge that ends an output period, that is, while the output is low. A toggle in the middle of a period has no effect until that edge.
- R5: A new ratio code is sampled only on the rising edge that ends the current output period. It takes effect on the period that starts at that edge.
- R6: clkOutN is always the inverse of clkOut.
- R7: While reset is asserted, the period counter is zero, the applied ratio is divide-by-2 and the applied enable is off, so clkOut is low.
- R8: At ratio 1, the enable passes through a latch that is transparent while the source clock is low. After the edge that applies an enable change, the output first shows or drops a source pulse one source cycle later. Every pulse that reaches the output is a full source high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ratioCode | input | 2 | Ratio select: 00 gives /2, 01 gives /4, 10 gives /8, 11 gives /1 |
| outEn | input | 1 | Output enable, active high |
| clkOut | output | 1 | Divided clock, true polarity |
| clkOutN | output | 1 | Divided clock, complement |

## Verification
The bench aims at edges where the ratio code or the enable changes in the middle of a period, at every ratio, including switches into and out of pass-through. A design that applied the code at once would show a shortened high or low half, and the bench would catch it in that half-cycle. Fast toggling of the enable at ratio 4 and at ratio 1 would expose a gate that is not synchronous: it would produce a clipped pulse or a pulse one cycle early. A wrong entry in the code map, or a counter that wraps one cycle late, would change the period length and fail the comparison with the reference model within one period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MAX_DIV = 8;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam int DIV_W   = CNT_W + 1;
  localparam logic [1:0] CODE_DIV1 = 2'b11;
  localparam logic [1:0] CODE_RESET = 2'b00;

  // strobes from control to datapath
  typedef struct packed {
    logic divHighNext; // value the divided flop takes at the coming edge
    logic oneGate;     // pass-through allowed during the next high phase
    logic wrap;        // current edge ends an output period
  } ctl_t;

  function automatic logic [DIV_W-1:0] ratioDivisor(input logic [1:0] code);
    case (code)
      2'b00:   ratioDivisor = DIV_W'(2);
      2'b01:   ratioDivisor = DIV_W'(4);
      2'b10:   ratioDivisor = DIV_W'(8);
      default: ratioDivisor = DIV_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  logic [1:0] ratioCode,
  input  logic       outEn,
  output ctl_t       ctl
);
  logic [CNT_W-1:0] cnt, cntNext;
  logic [1:0]       activeCode, codeNext;
  logic             gateOn, gateNext;
  logic [DIV_W-1:0] curDiv, nextDiv;
  logic             wrap;

  assign curDiv = ratioDivisor(activeCode);
  assign wrap   = ({1'b0, cnt} == (curDiv - DIV_W'(1)));

  always_comb begin
    if (wrap) begin
      cntNext  = '0;
      codeNext = ratioCode;
      gateNext = outEn;
    end else begin
      cntNext  = cnt + CNT_W'(1);
      codeNext = activeCode;
      gateNext = gateOn;
    end
  end

  assign nextDiv = ratioDivisor(codeNext);

  always_comb begin
    ctl.divHighNext = gateNext && (nextDiv >= DIV_W'(2)) &&
                      ({1'b0, cntNext} < (nextDiv >> 1));
    ctl.oneGate     = gateOn && (activeCode == CODE_DIV1);
    ctl.wrap        = wrap;
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      activeCode <= CODE_RESET;
      gateOn     <= 1'b0;
    end else begin
      cnt        <= cntNext;
      activeCode <= codeNext;
      gateOn     <= gateNext;
    end
  end

  // R2: counter stays inside the applied period
  assert_cnt_in_period_R2: assert property (@(posedge clkIn) disable iff (!rstN)
    {1'b0, cnt} < curDiv);
  // R5: applied code moves only at a period boundary
  assert_code_at_boundary_R5: assert property (@(posedge clkIn) disable iff (!rstN)
    (activeCode != $past(activeCode)) |-> $past(wrap));
  // R4: applied enable moves only at a period boundary
  assert_gate_at_boundary_R4: assert property (@(posedge clkIn) disable iff (!rstN)
    (gateOn != $past(gateOn)) |-> $past(wrap));
endmodule

// File: rtl/clkdiv_dpath.sv
module clkdiv_dpath
  import clkdiv_pkg::*;
(
  input  logic clkIn,
  input  logic rstN,
  input  ctl_t ctl,
  output logic clkOut,
  output logic clkOutN
);
  logic divQ;
  logic passQ;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) divQ <= 1'b0;
    else       divQ <= ctl.divHighNext;
  end

  // clock gate latch, open while the source clock is low
  always_latch begin
    if (!rstN)       passQ <= 1'b0;
    else if (!clkIn) passQ <= ctl.oneGate;
  end

  assign clkOut  = divQ | (clkIn & passQ);
  assign clkOutN = ~clkOut;

  // R4: a period only ends while the divided flop is low
  assert_low_at_wrap_R4: assert property (@(posedge clkIn) disable iff (!rstN)
    ctl.wrap |-> !divQ);
  // R8: the divided flop and pass-through never both drive in steady state
  assert_single_source_R8: assert property (@(posedge clkIn) disable iff (!rstN)
    (passQ && $past(passQ)) |-> !divQ);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  logic [1:0] ratioCode,
  input  logic       outEn,
  output logic       clkOut,
  output logic       clkOutN
);
  ctl_t ctl;

  clkdiv_ctrl u_ctrl (
    .clkIn(clkIn), .rstN(rstN), .ratioCode(ratioCode), .outEn(outEn), .ctl(ctl)
  );

  clkdiv_dpath u_dpath (
    .clkIn(clkIn), .rstN(rstN), .ctl(ctl), .clkOut(clkOut), .clkOutN(clkOutN)
  );

  // R7: output is low throughout reset
  assert_reset_low_R7: assert property (@(negedge clkIn) !rstN |-> !clkOut);
endmodule

// File: tb/clkdiv_top_bench.sv
`timescale 1ns/1ps
module clkdiv_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] ratioCode = 2'b00;
  logic outEn = 1'b0;
  logic clkOut, clkOutN;

  int total = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R7";

  logic [1:0] stCode = 2'b00;
  logic stEn = 1'b0;
  logic stRst = 1'b0;

  // reference model state
  int mCnt = 0, mDiv = 2;
  bit mGate = 0, latchNext = 0, latchHigh = 0;

  always #2.5 clk = ~clk;

  clkdiv_top u_clkdiv_top (
    .clkIn(clk), .rstN(rstN), .ratioCode(ratioCode), .outEn(outEn),
    .clkOut(clkOut), .clkOutN(clkOutN)
  );

  function automatic int decodeDiv(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mDiv = 2; mGate = 0; latchNext = 0; latchHigh = 0;
    end else begin
      latchHigh = latchNext;
      if (mCnt == mDiv - 1) begin
        mDiv = decodeDiv(ratioCode); mGate = outEn; mCnt = 0;
      end else mCnt++;
      latchNext = mGate && (mDiv == 1);
    end
  end

  function automatic bit divHigh();
    return mGate && (mDiv >= 2) && (mCnt < mDiv / 2);
  endfunction

  task automatic compare(input bit exp, input string phase);
    total++;
    if (clkOut !== exp) begin
      fails++;
      $display("FAIL %s (%s half, div %0d): clkOut=%b expected %b", tag, phase, mDiv, clkOut, exp);
    end
    total++;
    if (clkOutN !== ~exp) begin
      fails++;
      $display("FAIL R6 (%s half): clkOutN=%b expected %b", phase, clkOutN, ~exp);
    end
  endtask

  // one source cycle: check high half, apply stimulus, check low half
  task automatic cycle();
    @(posedge clk);
    #1.25 compare(latchHigh | divHigh(), "high");
    #0.25 begin ratioCode = stCode; outEn = stEn; rstN = stRst; end
    #2.25 compare(divHigh(), "low");
  endtask

  task automatic run(input int n, input logic [1:0] c, input logic e);
    stCode = c; stEn = e;
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    // R7: reset state
    tag = "R7";
    run(3, 2'b10, 1'b1);
    stRst = 1'b1;
    cycle();
    // R1/R2: every code held steady with the output enabled
    tag = "R1";
    run(40, 2'b00, 1'b1);
    run(40, 2'b01, 1'b1);
    run(40, 2'b10, 1'b1);
    tag = "R8";
    run(40, 2'b11, 1'b1);
    // R4: enable toggles in the middle of periods at ratio 4
    tag = "R4";
    for (int i = 0; i < 20; i++) run(3, 2'b01, i[0]);
    // R8: enable toggles at pass-through
    tag = "R8";
    for (int i = 0; i < 15; i++) run(2, 2'b11, i[0]);
    // R5: code changes at irregular points, including switches into and out of pass-through
    tag = "R5";
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      run(1 + lfsr[4:2], lfsr[1:0], 1'b1);
    end
    // R3: disabled output
    tag = "R3";
    run(30, 2'b10, 1'b0);
    run(10, 2'b11, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule